// File: doc/BRIEF.md
# Flash Program/Erase Status Reporter

This block produces the word that a parallel NOR-style flash device puts on its data bus while an internal program or erase runs. It holds a small operation controller with a programmable busy duration. It latches the top data bit being programmed and keeps a toggle flag that advances on each read strobe. From these it builds a status word with a polling bit, a toggle bit and an error bit. The storage array, the command decoder and the cell timing are not modelled. Plain request inputs stand in for the decoded commands, and a pattern input stands in for array contents.

An integrator drives a start request with a busy count. The bus-read value is then polled on `rd_data` while `rd_stb` is pulsed once per bus read. An erase can be suspended and resumed. A forced-failure input makes the operation end in the error state, which only the clear request leaves.

Top module: `flash_status_reporter`

## Requirements
- R1: After reset the block is idle, `rd_data` equals `array_data`, and the toggle bit (bit 6 of later status words) starts at 0.
- R2: While idle, `rd_data` equals `array_data`. After a program completes, the bit-7 value read is the array value and is not inverted.
- R3: While programming, `rd_data` bit 7 is the inverse of `prog_data` bit 7 captured at the start, bit 6 is the toggle bit, and bits 5..0 are 0.
- R4: While erasing, `rd_data` bit 7 is 0, bit 6 is the toggle bit, and bits 5..0 are 0.
- R5: The toggle bit inverts once for each rising edge of `rd_stb` seen while programming, erasing, suspending or failed. A strobe held high for several cycles counts once.
- R6: A program or erase that is not suspended stays busy for `busy_cycles`+1 clock cycles after the start cycle, then returns to idle.
- R7: `suspend_req` during an erase keeps the erase status word for SUSP_LAT cycles and then enters suspend. While suspended, a read with `in_erase_blk` high gives bit 7 = 1, bit 6 frozen, and bits 5..0 = 0.
- R8: While suspended, a read with `in_erase_blk` low returns `array_data`.
- R9: `resume_req` while suspended returns to erasing, and the erase continues with the busy count left at the time of the suspend.
- R10: If `force_fail` was high at the start, the operation ends in the failed state. That state gives bit 5 = 1, bit 7 as during the operation (inverted program bit, or 0 for erase), and bit 6 as the toggle bit.
- R11: `reset_cmd` moves the failed state to idle. In any other state it has no effect.
- R12: `prog_start` and `erase_start` are ignored unless the block is idle; the captured program bit is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prog_start | input | 1 | Begin a program operation |
| erase_start | input | 1 | Begin an erase operation |
| prog_data | input | DW | Data word being programmed |
| busy_cycles | input | CW | Busy duration minus one, in clock cycles |
| force_fail | input | 1 | Make the operation starting now end failed |
| suspend_req | input | 1 | Request erase suspend |
| resume_req | input | 1 | Resume a suspended erase |
| reset_cmd | input | 1 | Clear the failed state |
| in_erase_blk | input | 1 | Read address lies in the block being erased |
| array_data | input | DW | Stand-in for array contents |
| rd_stb | input | 1 | Bus read strobe; its rising edge advances the toggle bit |
| rd_data | output | DW | Word returned on a bus read |

## Verification
The hardest case to reach is a suspend with the toggle bit in a known non-zero phase. After that, a read inside the erased block must give a frozen bit 6, and an erase resumed from there must run exactly its remaining count. Directed sequences strobe an odd number of reads before the suspend and pulse the strobe while suspended. They then time the resumed erase cycle by cycle. A long random phase mixes starts, suspends, resumes, clears and strobes in every state against a bench reference model.

// File: rtl/fsr_pkg.sv
package fsr_pkg;
   typedef enum logic [2:0] {
      OP_IDLE    = 3'd0,
      OP_PROG    = 3'd1,
      OP_ERASE   = 3'd2,
      OP_SPNDING = 3'd3,
      OP_SUSP    = 3'd4,
      OP_FAIL    = 3'd5
   } op_state_e;

   localparam int POLL_POS = 7;
   localparam int TGL_POS  = 6;
   localparam int ERR_POS  = 5;
endpackage

// File: rtl/fsr_op_ctrl.sv
module fsr_op_ctrl
   import fsr_pkg::*;
#(
   parameter int CW       = 16,
   parameter int SUSP_LAT = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          prog_start,
   input  logic          erase_start,
   input  logic          suspend_req,
   input  logic          resume_req,
   input  logic          reset_cmd,
   input  logic          force_fail,
   input  logic [CW-1:0] busy_cycles,
   input  logic          prog_msb,
   output op_state_e     st,
   output logic          pd_msb,
   output logic          was_erase
);
   localparam int SW = (SUSP_LAT > 1) ? $clog2(SUSP_LAT) : 1;
   localparam op_state_e SUSP_ENTRY = (SUSP_LAT == 0) ? OP_SUSP : OP_SPNDING;

   initial begin
      assert (CW >= 1) else $fatal(1, "CW must be at least 1");
      assert (SUSP_LAT >= 0) else $fatal(1, "SUSP_LAT must not be negative");
   end

   logic [CW-1:0] cnt;
   logic          fail_q;
   logic          sus_done;
   logic          finish;

   assign finish = (cnt == '0);

   generate
      if (SUSP_LAT == 0) begin : g_sus_none
         assign sus_done = 1'b1;
      end else begin : g_sus_cnt
         logic [SW-1:0] sus_cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               sus_cnt <= '0;
            end else if (st == OP_ERASE && suspend_req) begin
               sus_cnt <= SW'(SUSP_LAT - 1);
            end else if (st == OP_SPNDING && sus_cnt != '0) begin
               sus_cnt <= sus_cnt - SW'(1);
            end
         end
         assign sus_done = (sus_cnt == '0);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= OP_IDLE;
         cnt       <= '0;
         pd_msb    <= 1'b0;
         was_erase <= 1'b0;
         fail_q    <= 1'b0;
      end else begin
         unique case (st)
            OP_IDLE: begin
               if (prog_start) begin
                  st        <= OP_PROG;
                  cnt       <= busy_cycles;
                  pd_msb    <= prog_msb;
                  was_erase <= 1'b0;
                  fail_q    <= force_fail;
               end else if (erase_start) begin
                  st        <= OP_ERASE;
                  cnt       <= busy_cycles;
                  was_erase <= 1'b1;
                  fail_q    <= force_fail;
               end
            end
            OP_PROG: begin
               if (finish) st <= fail_q ? OP_FAIL : OP_IDLE;
               else        cnt <= cnt - CW'(1);
            end
            OP_ERASE: begin
               if (suspend_req) st  <= SUSP_ENTRY;
               else if (finish) st  <= fail_q ? OP_FAIL : OP_IDLE;
               else             cnt <= cnt - CW'(1);
            end
            OP_SPNDING: begin
               if (sus_done) st <= OP_SUSP;
            end
            OP_SUSP: begin
               if (resume_req) st <= OP_ERASE;
            end
            OP_FAIL: begin
               if (reset_cmd) st <= OP_IDLE;
            end
            default: st <= OP_IDLE;
         endcase
      end
   end

   AST_CNT_DESCENDS: assert property (@(posedge clk) disable iff (!rst_n)
      (st == OP_PROG && cnt != '0) |=> (cnt == $past(cnt) - CW'(1))); // R6
   AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (st == OP_FAIL && !reset_cmd) |=> (st == OP_FAIL)); // R11
   AST_BUSY_KEEPS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
      (st == OP_PROG && cnt != '0) |=> (st == OP_PROG && pd_msb == $past(pd_msb))); // R12
endmodule

// File: rtl/fsr_toggle.sv
module fsr_toggle
   import fsr_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      rd_stb,
   input  op_state_e st,
   output logic      tog
);
   logic stb_q;
   logic active;

   assign active = (st == OP_PROG) || (st == OP_ERASE) ||
                   (st == OP_SPNDING) || (st == OP_FAIL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stb_q <= 1'b0;
         tog   <= 1'b0;
      end else begin
         stb_q <= rd_stb;
         if (active && rd_stb && !stb_q) tog <= ~tog;
      end
   end

   AST_TGL_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (st == OP_SUSP || st == OP_IDLE) |=> $stable(tog)); // R7
   AST_TGL_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stb && stb_q) |=> $stable(tog)); // R5
endmodule

// File: rtl/fsr_word_mux.sv
module fsr_word_mux
   import fsr_pkg::*;
#(
   parameter int DW = 8
) (
   input  op_state_e     st,
   input  logic          tog,
   input  logic          pd_msb,
   input  logic          was_erase,
   input  logic          in_blk,
   input  logic [DW-1:0] array_data,
   output logic [DW-1:0] word
);
   always_comb begin
      word = '0;
      unique case (st)
         OP_IDLE: word = array_data;
         OP_PROG: begin
            word[POLL_POS] = ~pd_msb;
            word[TGL_POS]  = tog;
         end
         OP_ERASE, OP_SPNDING: begin
            word[TGL_POS] = tog;
         end
         OP_SUSP: begin
            if (in_blk) begin
               word[POLL_POS] = 1'b1;
               word[TGL_POS]  = tog;
            end else begin
               word = array_data;
            end
         end
         OP_FAIL: begin
            word[POLL_POS] = was_erase ? 1'b0 : ~pd_msb;
            word[TGL_POS]  = tog;
            word[ERR_POS]  = 1'b1;
         end
         default: word = array_data;
      endcase
   end
endmodule

// File: rtl/flash_status_reporter.sv
module flash_status_reporter
   import fsr_pkg::*;
#(
   parameter int DW       = 8,
   parameter int CW       = 16,
   parameter int SUSP_LAT = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          prog_start,
   input  logic          erase_start,
   input  logic [DW-1:0] prog_data,
   input  logic [CW-1:0] busy_cycles,
   input  logic          force_fail,
   input  logic          suspend_req,
   input  logic          resume_req,
   input  logic          reset_cmd,
   input  logic          in_erase_blk,
   input  logic [DW-1:0] array_data,
   input  logic          rd_stb,
   output logic [DW-1:0] rd_data
);
   initial begin
      assert (DW >= 8) else $fatal(1, "DW must hold the status bits");
   end

   op_state_e st;
   logic      pd_msb;
   logic      was_erase;
   logic      tog;

   fsr_op_ctrl #(.CW(CW), .SUSP_LAT(SUSP_LAT)) u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .prog_start  (prog_start),
      .erase_start (erase_start),
      .suspend_req (suspend_req),
      .resume_req  (resume_req),
      .reset_cmd   (reset_cmd),
      .force_fail  (force_fail),
      .busy_cycles (busy_cycles),
      .prog_msb    (prog_data[POLL_POS]),
      .st          (st),
      .pd_msb      (pd_msb),
      .was_erase   (was_erase)
   );

   fsr_toggle u_tgl (
      .clk    (clk),
      .rst_n  (rst_n),
      .rd_stb (rd_stb),
      .st     (st),
      .tog    (tog)
   );

   fsr_word_mux #(.DW(DW)) u_mux (
      .st         (st),
      .tog        (tog),
      .pd_msb     (pd_msb),
      .was_erase  (was_erase),
      .in_blk     (in_erase_blk),
      .array_data (array_data),
      .word       (rd_data)
   );

   AST_IDLE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      (st == OP_IDLE) |-> (rd_data == array_data)); // R2
endmodule

// File: tb/tb_flash_status_reporter.sv
`timescale 1ns/1ps
module tb_flash_status_reporter;
   localparam int DW = 8;
   localparam int CW = 16;
   localparam int SL = 4;

   localparam logic [2:0] M_IDLE = 3'd0, M_PROG = 3'd1, M_ERASE = 3'd2,
                          M_SPND = 3'd3, M_SUSP = 3'd4, M_FAIL = 3'd5;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          prog_start = 0, erase_start = 0, force_fail = 0;
   logic          suspend_req = 0, resume_req = 0, reset_cmd = 0;
   logic          in_erase_blk = 0, rd_stb = 0;
   logic [DW-1:0] prog_data = '0, array_data = '0;
   logic [CW-1:0] busy_cycles = '0;
   logic [DW-1:0] rd_data;

   int checks = 0;
   int errors = 0;
   bit run_chk = 0;

   always #2.5 clk = ~clk;

   flash_status_reporter #(.DW(DW), .CW(CW), .SUSP_LAT(SL)) dut (
      .clk(clk), .rst_n(rst_n), .prog_start(prog_start), .erase_start(erase_start),
      .prog_data(prog_data), .busy_cycles(busy_cycles), .force_fail(force_fail),
      .suspend_req(suspend_req), .resume_req(resume_req), .reset_cmd(reset_cmd),
      .in_erase_blk(in_erase_blk), .array_data(array_data), .rd_stb(rd_stb),
      .rd_data(rd_data)
   );

   // reference model built from the requirements
   logic [2:0]    m_st;
   logic [CW-1:0] m_cnt;
   int            m_sus;
   logic          m_tog, m_pd7, m_fail, m_er, m_stbq;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_st <= M_IDLE; m_cnt <= '0; m_sus <= 0; m_tog <= 0;
         m_pd7 <= 0; m_fail <= 0; m_er <= 0; m_stbq <= 0;
      end else begin
         m_stbq <= rd_stb;
         if (rd_stb && !m_stbq && (m_st == M_PROG || m_st == M_ERASE ||
             m_st == M_SPND || m_st == M_FAIL)) m_tog <= ~m_tog;
         case (m_st)
            M_IDLE: if (prog_start) begin
                  m_st <= M_PROG; m_cnt <= busy_cycles; m_pd7 <= prog_data[7];
                  m_er <= 0; m_fail <= force_fail;
               end else if (erase_start) begin
                  m_st <= M_ERASE; m_cnt <= busy_cycles; m_er <= 1; m_fail <= force_fail;
               end
            M_PROG, M_ERASE: begin
               if (m_st == M_ERASE && suspend_req) begin
                  m_st <= M_SPND; m_sus <= SL - 1;
               end else if (m_cnt == 0) m_st <= m_fail ? M_FAIL : M_IDLE;
               else m_cnt <= m_cnt - 1;
            end
            M_SPND: if (m_sus == 0) m_st <= M_SUSP; else m_sus <= m_sus - 1;
            M_SUSP: if (resume_req) m_st <= M_ERASE;
            M_FAIL: if (reset_cmd) m_st <= M_IDLE;
            default: m_st <= M_IDLE;
         endcase
      end
   end

   function automatic logic [7:0] exp_word(input logic [2:0] s, input logic t,
         input logic p7, input logic er, input logic blk, input logic [7:0] arr);
      case (s)
         M_PROG:         return {~p7, t, 6'b0};
         M_ERASE, M_SPND: return {1'b0, t, 6'b0};
         M_SUSP:         return blk ? {1'b1, t, 6'b0} : arr;
         M_FAIL:         return {(er ? 1'b0 : ~p7), t, 1'b1, 5'b0};
         default:        return arr;
      endcase
   endfunction

   function automatic string tag_of(input logic [2:0] s, input logic blk);
      case (s)
         M_PROG:  return "R3";
         M_ERASE: return "R4";
         M_SPND:  return "R7";
         M_SUSP:  return blk ? "R7" : "R8";
         M_FAIL:  return "R10";
         default: return "R2";
      endcase
   endfunction

   task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s (R5 toggle included): got %h expected %h at %0t", tag, got, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && run_chk) begin
         #2;
         chk(tag_of(m_st, in_erase_blk), rd_data,
             exp_word(m_st, m_tog, m_pd7, m_er, in_erase_blk, array_data));
      end
   end

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
   endtask

   initial begin
      #1_000_000;
      errors++;
      $display("FAIL R6 watchdog: got no completion expected completion");
      summary();
      $finish;
   end

   initial begin
      void'($urandom(32'd4242));
      array_data = 8'h5A;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1 chk("R1", rd_data, 8'h5A);
      run_chk = 1;

      // program with held strobe, ignored starts and clear
      busy_cycles = 16'd3; prog_data = 8'h80; prog_start = 1;
      tick(); prog_start = 0;
      #1 chk("R3", rd_data, 8'h00);
      prog_start = 1; erase_start = 1; prog_data = 8'h00; reset_cmd = 1; rd_stb = 1;
      tick(); prog_start = 0; erase_start = 0; reset_cmd = 0;
      #1 chk("R12", rd_data, 8'h40);
      #0 chk("R11", rd_data, 8'h40);
      tick();
      #1 chk("R5", rd_data, 8'h40);
      rd_stb = 0;
      tick();
      #1 chk("R6", rd_data, 8'h40);
      array_data = 8'h80;
      tick();
      #1 chk("R6", rd_data, 8'h80);
      #0 chk("R2", rd_data, 8'h80);

      // erase, suspend, resume
      busy_cycles = 16'd5; erase_start = 1;
      tick(); erase_start = 0;
      #1 chk("R4", rd_data, 8'h40);
      suspend_req = 1;
      tick(); suspend_req = 0; in_erase_blk = 1;
      #1 chk("R7", rd_data, 8'h40);
      repeat (3) tick();
      #1 chk("R7", rd_data, 8'h40);
      tick();
      #1 chk("R7", rd_data, 8'hC0);
      rd_stb = 1; tick(); rd_stb = 0; tick();
      #1 chk("R7", rd_data, 8'hC0);
      in_erase_blk = 0; array_data = 8'h3C;
      #1 chk("R8", rd_data, 8'h3C);
      resume_req = 1;
      tick(); resume_req = 0;
      #1 chk("R9", rd_data, 8'h40);
      repeat (5) tick();
      #1 chk("R9", rd_data, 8'h40);
      tick();
      #1 chk("R9", rd_data, 8'h3C);

      // forced failure of a program
      busy_cycles = 16'd0; prog_data = 8'h00; force_fail = 1; prog_start = 1;
      tick(); prog_start = 0; force_fail = 0;
      #1 chk("R3", rd_data, 8'hC0);
      tick();
      #1 chk("R10", rd_data, 8'hE0);
      rd_stb = 1; tick(); rd_stb = 0;
      #1 chk("R10", rd_data, 8'hA0);
      tick();
      #1 chk("R11", rd_data, 8'hA0);
      reset_cmd = 1;
      tick(); reset_cmd = 0;
      #1 chk("R11", rd_data, 8'h3C);

      // constrained random phase
      for (int i = 0; i < 4000; i++) begin
         tick();
         prog_start   = ($urandom_range(0, 9) == 0);
         erase_start  = ($urandom_range(0, 9) == 0);
         prog_data    = 8'($urandom);
         busy_cycles  = 16'($urandom_range(0, 12));
         force_fail   = ($urandom_range(0, 3) == 0);
         suspend_req  = ($urandom_range(0, 15) == 0);
         resume_req   = ($urandom_range(0, 7) == 0);
         reset_cmd    = ($urandom_range(0, 7) == 0);
         in_erase_blk = $urandom_range(0, 1) == 1;
         array_data   = 8'($urandom);
         rd_stb       = $urandom_range(0, 1) == 1;
      end
      tick();
      run_chk = 0;
      summary();
      $finish;
   end
endmodule